// File: doc/BRIEF.md
# I2C Pointer-Register Target

This block is an I2C target that exposes a bank of 16-bit registers through an 8-bit pointer. It samples the SCL and SDA lines with the system clock. Each line passes through a two-flop synchronizer and a short glitch filter. The block then detects START, STOP and repeated START, and the only thing it drives onto the bus is an open-drain pull-down enable for SDA. The register contents are held outside the block. The block presents one address to that bank, reads a 16-bit word back, and receives two attribute bits for the presented address: whether the address is implemented, and whether it is read-only.

A write transaction always loads the first byte after the address byte into the pointer. Any further bytes are data, taken in pairs: the high byte first, then the low byte. Each pair is committed as a single 16-bit write strobe. A read transaction returns the word at the last pointer written, high byte first. The pointer is not changed by a read.

The block accepts or refuses each byte with ACK or NACK, and the choice follows fixed rules:
- the target address must match;
- the pointer must select an implemented register;
- data is refused for read-only registers;
- for a set number of clock cycles after reset, only the serial-number range at the top of the address space may be selected.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset, and whenever no transfer is addressed to the block, `sda_oe` is 0 and `reg_we` is 0.
- R2: The address byte is ACKed (SDA pulled low on the ninth clock) only when its upper seven bits equal 7'b1000000. Bit 0 is the direction: 0 means write, 1 means read. Any other address is NACKed, and the block stays silent until the next START or STOP.
- R3: In a write transaction, the first byte after the address byte is loaded into the pointer. The pointer is loaded even when that byte is NACKed. A transaction made of only the address and pointer bytes, followed by STOP or repeated START, only updates the pointer.
- R4: Data bytes to a writable, implemented register are ACKed. They are taken in pairs, high byte first. After the ACK of the second byte, `reg_we` pulses for exactly one cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to {high, low}.
- R5: A read transaction returns the word at the current pointer: bits 15..8 first, then bits 7..0, each byte MSB first. Repeated reads without a new pointer write return the same register.
- R6: A pointer value that selects an unimplemented address is NACKed on the pointer byte. Data bytes that follow it are NACKed and cause no write.
- R7: Each data byte written to a read-only register is NACKed, and no write strobe is issued.
- R8: For PWR_CYCLES clock cycles after reset, a pointer below 0xFB is NACKed at the pointer byte, while pointers 0xFB to 0xFF are ACKed and readable. After that window, implemented pointers are ACKed regardless of their value.
- R9: During a read, a master NACK after a byte ends the transfer. SDA stays released until the next START or STOP, including during any further clocks.
- R10: A START or STOP in the middle of a transaction returns the byte logic to address receive or to idle. It discards an incomplete data pair and keeps the pointer.
- R11: `sda_oe` changes only while SCL is low.
- R12: A pulse on SCL shorter than the filter length is ignored and does not count as a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | 8 | Register address presented to the bank |
| reg_wdata | output | 16 | Word to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Word read from the bank at `reg_addr` |
| reg_impl | input | 1 | The address on `reg_addr` is implemented |
| reg_ro | input | 1 | The address on `reg_addr` is read-only |

## Verification
A wrong bit count or phase in the byte logic shows up at the ports within one byte. It appears as an ACK in the wrong slot, a shifted read byte, or SDA held low through STOP. A wrong pointer or attribute decision shows up as a flipped ACK bit on the pointer byte, or as a `reg_we` strobe that is unexpected or missing. The per-clock comparison catches such a strobe in the cycle it occurs. A broken power-up counter only shows up as an ACK of a low pointer during the window, so the pointer is probed inside the window and again after it.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_WR,
        PH_RD,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    localparam int BYTE_BITS = 8;
    localparam int ACK_SLOT  = BYTE_BITS;
    localparam int END_SLOT  = BYTE_BITS + 1;

    function automatic logic in_serial_range(input logic [7:0] a, input logic [7:0] lo);
        return a >= lo;
    endfunction

endpackage

// File: rtl/i2cp_line_filter.sv
module i2cp_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            clean  <= 1'b1;
            run_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == clean) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                clean <= sync_q[1];
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cp_bus_events.sv
module i2cp_bus_events
    import i2cp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl,
    input  logic    sda,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    always_comb begin
        ev.start    = scl_q && scl && sda_q && !sda;
        ev.stop     = scl_q && scl && !sda_q && sda;
        ev.scl_rise = !scl_q && scl;
        ev.scl_fall = scl_q && !scl;
        ev.sda      = sda;
    end
endmodule

// File: rtl/i2cp_access_gate.sv
module i2cp_access_gate
    import i2cp_pkg::*;
#(
    parameter int         PWR_CYCLES = 1_500_000,
    parameter logic [7:0] SERIAL_LO  = 8'hFB
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cand_addr,
    input  logic       cand_impl,
    output logic       in_window,
    output logic       ptr_accept
);
    localparam int TW = $clog2(PWR_CYCLES + 2);

    logic [TW-1:0] tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
        end else if (tick_q != TW'(PWR_CYCLES)) begin
            tick_q <= tick_q + 1'b1;
        end
    end

    assign in_window  = (tick_q != TW'(PWR_CYCLES));
    assign ptr_accept = cand_impl && (!in_window || in_serial_range(cand_addr, SERIAL_LO));
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
    import i2cp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'b1000000,
    parameter int         FILT_LEN   = 3,
    parameter int         PWR_CYCLES = 1_500_000,
    parameter logic [7:0] SERIAL_LO  = 8'hFB
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [7:0]  reg_addr,
    output logic [15:0] reg_wdata,
    output logic        reg_we,
    input  logic [15:0] reg_rdata,
    input  logic        reg_impl,
    input  logic        reg_ro
);
    localparam int NLINES = 2;
    localparam int BCW    = $clog2(END_SLOT + 1);

    logic [NLINES-1:0] raw_lines, clean_lines;
    bus_ev_t           ev;
    logic              in_window, ptr_accept;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2cp_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    i2cp_bus_events u_ev (
        .clk (clk),
        .rst (rst),
        .scl (clean_lines[1]),
        .sda (clean_lines[0]),
        .ev  (ev)
    );

    phase_e         ph_q;
    logic [BCW-1:0] bit_q;
    logic [7:0]     rx_q, tx_q, lo_q, hi_q, ptr_q;
    logic           match_q, rw_q, ptr_ok_q, dat_ok_q, half_q, mack_q;

    assign reg_addr = (ph_q == PH_PTR) ? rx_q : ptr_q;

    i2cp_access_gate #(.PWR_CYCLES(PWR_CYCLES), .SERIAL_LO(SERIAL_LO)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .cand_addr  (reg_addr),
        .cand_impl  (reg_impl),
        .in_window  (in_window),
        .ptr_accept (ptr_accept)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_IDLE;
            bit_q     <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            lo_q      <= '0;
            hi_q      <= '0;
            ptr_q     <= '0;
            match_q   <= 1'b0;
            rw_q      <= 1'b0;
            ptr_ok_q  <= 1'b0;
            dat_ok_q  <= 1'b0;
            half_q    <= 1'b0;
            mack_q    <= 1'b0;
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (ev.stop) begin
                ph_q   <= PH_IDLE;
                bit_q  <= '0;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                ph_q   <= PH_ADDR;
                bit_q  <= '0;
                sda_oe <= 1'b0;
            end else if (ev.scl_rise) begin
                unique case (ph_q)
                    PH_ADDR, PH_PTR, PH_WR: begin
                        if (bit_q < BCW'(ACK_SLOT)) begin
                            rx_q  <= {rx_q[6:0], ev.sda};
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                    PH_RD: begin
                        if (bit_q < BCW'(ACK_SLOT)) bit_q <= bit_q + 1'b1;
                        else if (bit_q == BCW'(END_SLOT)) mack_q <= !ev.sda;
                    end
                    default: ;
                endcase
            end else if (ev.scl_fall) begin
                unique case (ph_q)
                    PH_ADDR: begin
                        if (bit_q == BCW'(ACK_SLOT)) begin
                            match_q <= (rx_q[7:1] == DEV_ADDR);
                            rw_q    <= rx_q[0];
                            sda_oe  <= (rx_q[7:1] == DEV_ADDR);
                            bit_q   <= BCW'(END_SLOT);
                        end else if (bit_q == BCW'(END_SLOT)) begin
                            sda_oe <= 1'b0;
                            bit_q  <= '0;
                            if (!match_q) begin
                                ph_q <= PH_SKIP;
                            end else if (rw_q) begin
                                ph_q   <= PH_RD;
                                tx_q   <= reg_rdata[15:8];
                                lo_q   <= reg_rdata[7:0];
                                half_q <= 1'b1;
                                sda_oe <= !reg_rdata[15];
                            end else begin
                                ph_q <= PH_PTR;
                            end
                        end
                    end
                    PH_PTR: begin
                        if (bit_q == BCW'(ACK_SLOT)) begin
                            ptr_q    <= rx_q;
                            ptr_ok_q <= ptr_accept;
                            sda_oe   <= ptr_accept;
                            bit_q    <= BCW'(END_SLOT);
                        end else if (bit_q == BCW'(END_SLOT)) begin
                            sda_oe <= 1'b0;
                            bit_q  <= '0;
                            half_q <= 1'b0;
                            ph_q   <= PH_WR;
                        end
                    end
                    PH_WR: begin
                        if (bit_q == BCW'(ACK_SLOT)) begin
                            dat_ok_q <= ptr_ok_q && !reg_ro;
                            sda_oe   <= ptr_ok_q && !reg_ro;
                            if (!half_q) hi_q <= rx_q;
                            bit_q <= BCW'(END_SLOT);
                        end else if (bit_q == BCW'(END_SLOT)) begin
                            sda_oe <= 1'b0;
                            bit_q  <= '0;
                            half_q <= !half_q;
                            if (half_q && dat_ok_q) begin
                                reg_we    <= 1'b1;
                                reg_wdata <= {hi_q, rx_q};
                            end
                        end
                    end
                    PH_RD: begin
                        if (bit_q < BCW'(ACK_SLOT)) begin
                            sda_oe <= !tx_q[3'd7 - bit_q[2:0]];
                        end else if (bit_q == BCW'(ACK_SLOT)) begin
                            sda_oe <= 1'b0;
                            bit_q  <= BCW'(END_SLOT);
                        end else begin
                            if (mack_q) begin
                                bit_q  <= '0;
                                half_q <= !half_q;
                                if (half_q) begin
                                    tx_q   <= lo_q;
                                    sda_oe <= !lo_q[7];
                                end else begin
                                    tx_q   <= reg_rdata[15:8];
                                    lo_q   <= reg_rdata[7:0];
                                    sda_oe <= !reg_rdata[15];
                                end
                            end else begin
                                ph_q   <= PH_SKIP;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    logic unused_ok;
    assign unused_ok = in_window;
endmodule

// File: rtl/i2cp_target_chk.sv
module i2cp_target_chk #(
    parameter int         PWR_CYCLES = 1_500_000,
    parameter logic [7:0] SERIAL_LO  = 8'hFB
) (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [7:0] reg_addr,
    input logic       reg_impl,
    input logic       reg_ro
);
    localparam int TW = $clog2(PWR_CYCLES + 2);

    logic [TW-1:0] age_q;
    logic          early;

    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != TW'(PWR_CYCLES)) age_q <= age_q + 1'b1;
    end
    assign early = (age_q != TW'(PWR_CYCLES));

    // R4: the write strobe is a single-cycle pulse
    p_we_single_r4: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    // R6: no write lands on an unimplemented address
    p_we_impl_r6: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> reg_impl);

    // R7: no write lands on a read-only address
    p_we_ro_r7: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !reg_ro);

    // R8: inside the power-up window only the serial range can be reached
    p_window_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && early) |-> (reg_addr >= SERIAL_LO));

    // R11: SDA drive moves only while SCL is low
    p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_ptr_target i2cp_target_chk #(
    .PWR_CYCLES (PWR_CYCLES),
    .SERIAL_LO  (SERIAL_LO)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_impl (reg_impl),
    .reg_ro   (reg_ro)
);

// File: tb/i2c_ptr_target_test.sv
module i2c_ptr_target_test;
    localparam int PWR = 4000;
    localparam int Q   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, reg_we, reg_impl, reg_ro;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic sda_line;

    int errors = 0, checks = 0, cyc = 0, oe_viol = 0;
    logic [15:0] mem [256];
    logic [23:0] expq [$];
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    function automatic logic is_impl(input logic [7:0] a);
        return (a <= 8'h02) || (a >= 8'hFB);
    endfunction
    function automatic logic is_ro(input logic [7:0] a);
        return (a == 8'h00) || (a >= 8'hFB);
    endfunction

    assign reg_rdata = mem[reg_addr];
    assign reg_impl  = is_impl(reg_addr);
    assign reg_ro    = is_ro(reg_addr);

    i2c_ptr_target #(.PWR_CYCLES(PWR)) uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .reg_impl(reg_impl), .reg_ro(reg_ro)
    );

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // per-clock reference comparison: strobes, bank update, SDA timing
    always @(negedge clk) begin
        if (!rst) cyc++;
        if (!rst && reg_we) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4 unexpected write strobe", {reg_addr, reg_wdata}, 0);
            end else begin
                logic [23:0] e;
                e = expq.pop_front();
                chk({reg_addr, reg_wdata} == e, "R4 write address/data", {reg_addr, reg_wdata}, e);
            end
            mem[reg_addr] = reg_wdata;
        end
        if (!rst && (sda_oe != prev_oe) && scl_m) oe_viol++;
        prev_oe = sda_oe;
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask
    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send(input logic [7:0] b, input logic glitch, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            if (glitch && i == 7) begin
                scl_m = 1'b1; @(negedge clk); scl_m = 1'b0; wq();
            end
            scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = !sda_line;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
        end
        wq(); sda_m = give_ack ? 1'b0 : 1'b1; wq(); scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq(); sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p, output logic a_ack, output logic p_ack);
        bus_start(); send(8'h80, 1'b0, a_ack); send(p, 1'b0, p_ack); bus_stop();
    endtask

    task automatic read_word(output logic a_ack, output logic [15:0] w);
        logic [7:0] h, l;
        bus_start(); send(8'h81, 1'b0, a_ack);
        recv(1'b1, h); recv(1'b0, l); bus_stop();
        w = {h, l};
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a, p, d0, d1;
        logic [15:0] w, w2;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) mem[i] = {i[7:0], ~i[7:0]};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sda_oe == 1'b0 && reg_we == 1'b0, "R1 idle after reset", {sda_oe, reg_we}, 0);

        // R8: inside the power-up window
        set_ptr(8'h01, a, p);
        chk(a == 1'b1, "R2 own address ACK", a, 1);
        chk(p == 1'b0, "R8 low pointer NACK in window", p, 0);
        set_ptr(8'hFB, a, p);
        chk(p == 1'b1, "R8 serial pointer ACK in window", p, 1);
        read_word(a, w);
        chk(w == mem[8'hFB], "R8 serial read in window", w, mem[8'hFB]);
        wait (cyc > PWR + 100);

        // R2: foreign address
        bus_start(); send(8'h82, 1'b0, a); bus_stop();
        chk(a == 1'b0, "R2 foreign address NACK", a, 0);
        chk(sda_oe == 1'b0, "R1 released after foreign address", sda_oe, 0);

        // R4: full write to a writable register
        expq.push_back({8'h02, 16'h1234});
        bus_start(); send(8'h80, 1'b0, a); send(8'h02, 1'b0, p);
        send(8'h12, 1'b0, d0); send(8'h34, 1'b0, d1); bus_stop();
        chk(p && d0 && d1, "R4 pointer and data ACKs", {p, d0, d1}, 3'b111);
        read_word(a, w);
        chk(w == 16'h1234, "R5 read back written word", w, 16'h1234);

        // R3/R5: pointer-only write, repeated reads
        set_ptr(8'h01, a, p);
        chk(p == 1'b1, "R3 pointer-only write ACK", p, 1);
        read_word(a, w);
        read_word(a, w2);
        chk(w == mem[1], "R3 read follows new pointer", w, mem[1]);
        chk(w2 == w, "R5 pointer unchanged by read", w2, w);

        // R6: unimplemented pointer
        bus_start(); send(8'h80, 1'b0, a); send(8'h10, 1'b0, p);
        send(8'hAA, 1'b0, d0); send(8'h55, 1'b0, d1); bus_stop();
        chk(p == 1'b0, "R6 unused pointer NACK", p, 0);
        chk(!d0 && !d1, "R6 data after unused pointer NACK", {d0, d1}, 0);

        // R7: read-only register
        bus_start(); send(8'h80, 1'b0, a); send(8'h00, 1'b0, p);
        send(8'hDE, 1'b0, d0); send(8'hAD, 1'b0, d1); bus_stop();
        chk(p == 1'b1, "R7 read-only pointer ACK", p, 1);
        chk(!d0 && !d1, "R7 read-only data NACK", {d0, d1}, 0);
        read_word(a, w);
        chk(w == 16'h00FF, "R7 read-only value unchanged", w, 16'h00FF);

        // R9: master NACK ends the read
        set_ptr(8'h02, a, p);
        bus_start(); send(8'h81, 1'b0, a); recv(1'b0, b);
        chk(b == 8'h12, "R5 high byte first", b, 8'h12);
        recv(1'b0, b);
        chk(b == 8'hFF, "R9 SDA released after master NACK", b, 8'hFF);
        bus_stop();

        // R10: repeated start mid-write keeps the pointer, drops the half pair
        bus_start(); send(8'h80, 1'b0, a); send(8'h02, 1'b0, p); send(8'h77, 1'b0, d0);
        bus_start(); send(8'h81, 1'b0, a);
        recv(1'b1, b); w[15:8] = b; recv(1'b0, b); w[7:0] = b; bus_stop();
        chk(w == 16'h1234, "R10 pointer kept, no write after restart", w, 16'h1234);

        // R12: short SCL pulse ignored
        bus_start(); send(8'h80, 1'b0, a); send(8'h01, 1'b1, p); bus_stop();
        read_word(a, w);
        chk(p && w == mem[1], "R12 glitch ignored", w, mem[1]);

        chk(expq.size() == 0, "R4 all expected writes seen", expq.size(), 0);
        chk(oe_viol == 0, "R11 SDA changed only with SCL low", oe_viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule